// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Start-Bit Qualification

This block turns an asynchronous serial line into characters for a receive FIFO. A one-cycle sample enable paces it. That enable pulses sixteen times per bit period in the normal oversampled mode, or once per bit clock in direct-clocked mode. While the receiver is enabled it looks for a falling edge on the line. In oversampled mode it confirms the start bit near the middle of that bit and rejects short pulses. It then samples each following bit near its centre, least significant bit first. The character may be five to eight bits long and may carry a parity bit.

Each finished character is written to the FIFO as one 11-bit word: eight data bits (bits 7:0) and three status flags. Bit 8 is the parity error flag, bit 9 the framing error flag and bit 10 the break flag. Data bits above the programmed character length are written as zero. An all-zero frame whose stop bit is low and whose line stays low for another half bit is written once as a break. The receiver then waits for the line to go high before it hunts again.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, and with the line idle high, `fifo_wr` stays low.
- R2: In oversampled mode a low level is accepted as a start bit only if it is still low on the 8th sample tick after the tick that saw the falling edge. Otherwise no entry is written and a falling edge on the very next tick starts a new frame.
- R3: Data bits are sampled every 16 ticks after the start check, least significant bit first. `char_len` codes 0, 1, 2, 3 select 5, 6, 7, 8 data bits.
- R4: Data bits at and above the character length are zero in the written word.
- R5: With `par_en` high, one parity bit follows the data. `par_odd` = 1 selects odd parity and 0 selects even. Bit 8 is set when the parity bit does not match.
- R6: A stop bit sampled low sets bit 9.
- R7: The entry is written as a one-clock `fifo_wr` pulse on the clock after the tick that samples the middle of the stop bit (the 9th tick of the stop bit in oversampled mode). The one exception is a break candidate (R8).
- R8: A candidate frame has all data bits zero, a zero parity bit when parity is enabled, and a low stop bit. It is written half a bit period after the stop sample (8 ticks, or 1 tick in direct mode). If the line is still low, the entry is 0x600 (data 0, bit 9 and bit 10 set, bit 8 clear) and is written only once. Nothing more is received until the line returns high. If the line is high by then, a framing-error entry is written instead.
- R9: With `mode_1x` high, a low sample on a tick after a high sample is taken as the start bit, and each following tick samples one bit.
- R10: While `rx_en` is low, the receiver writes nothing and any frame in progress is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| tick_en | input | 1 | Sample enable: 16 per bit period, or 1 per bit in direct mode |
| mode_1x | input | 1 | Direct-clocked mode select |
| char_len | input | 2 | Data length code, 0..3 selects 5..8 bits |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| rxd | input | 1 | Serial line, idle high |
| fifo_wr | output | 1 | One-clock write strobe for the receive FIFO |
| fifo_data | output | 11 | Break, framing error, parity error, data[7:0] |

## Verification
The assertions assume that `char_len`, `par_en`, `par_odd` and `mode_1x` change only while the receiver is hunting. They also assume that `rxd` is already synchronised to `clk` and changes only between sample ticks. The stimulus follows both rules: it changes the frame format and the mode only on an idle line between frames. It drives the line at a clock edge away from the ticks and holds each level for a whole number of tick periods. The checks also expect ticks to be at least two clocks apart, because a write pulse must end before the next tick. The bench keeps them four clocks apart.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_W  = 8;
  localparam int ENTRY_W = DATA_W + 3;
  localparam int PE_POS  = DATA_W;
  localparam int FE_POS  = DATA_W + 1;
  localparam int BRK_POS = DATA_W + 2;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BRKQ,
    ST_BRKWAIT
  } rx_state_e;
endpackage

// File: rtl/rx_tick_counter.sv
module rx_tick_counter #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  input  logic mode_1x,
  output logic half_hit,
  output logic full_hit
);
  localparam int CNT_W = $clog2(OSR);
  localparam int HALF  = OSR / 2;

  logic [CNT_W-1:0] cnt, cnt_n;

  assign half_hit = tick && (mode_1x || (cnt == CNT_W'(HALF - 1)));
  assign full_hit = tick && (mode_1x || (cnt == CNT_W'(OSR - 1)));

  always_comb begin
    cnt_n = cnt;
    if (clr)           cnt_n = '0;
    else if (full_hit) cnt_n = '0;
    else if (tick)     cnt_n = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end
endmodule

// File: rtl/rx_shift_asm.sv
module rx_shift_asm #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          shift_en,
  input  logic          bit_in,
  input  logic [1:0]    len_code,
  output logic [DW-1:0] data_out,
  output logic          par_x
);
  logic [DW-1:0] sh, sh_n;
  logic [2:0]    sh_amt;

  // Bits enter at the top, so a short character is aligned down
  // by the number of unused positions; zeros fill from above.
  assign sh_amt   = 3'd3 - {1'b0, len_code};
  assign data_out = sh >> sh_amt;
  assign par_x    = ^data_out;

  always_comb begin
    sh_n = sh;
    if (clr)           sh_n = '0;
    else if (shift_en) sh_n = {bit_in, sh[DW-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= sh_n;
  end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_en,
  input  logic               tick_en,
  input  logic               mode_1x,
  input  logic [1:0]         char_len,
  input  logic               par_en,
  input  logic               par_odd,
  input  logic               rxd,
  output logic               fifo_wr,
  output logic [ENTRY_W-1:0] fifo_data
);
  rx_state_e           state, state_n;
  logic [2:0]          bcnt, bcnt_n;
  logic                pbit, pbit_n;
  logic                rx_q;
  logic                wr_q, wr_n;
  logic [ENTRY_W-1:0]  wdata, wdata_n;
  logic                clr_cnt, sh_clr, sh_en;
  logic                half_hit, full_hit;
  logic [DATA_W-1:0]   data_al;
  logic                par_x, perr;
  logic [2:0]          last_bit;

  rx_tick_counter #(.OSR(OSR)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .clr(clr_cnt),
    .mode_1x(mode_1x), .half_hit(half_hit), .full_hit(full_hit)
  );

  rx_shift_asm #(.DW(DATA_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .clr(sh_clr), .shift_en(sh_en),
    .bit_in(rxd), .len_code(char_len), .data_out(data_al), .par_x(par_x)
  );

  assign last_bit = {1'b0, char_len} + 3'd4;
  assign perr     = par_en && (par_x ^ pbit ^ par_odd);

  always_comb begin
    state_n = state;
    bcnt_n  = bcnt;
    pbit_n  = pbit;
    wr_n    = 1'b0;
    wdata_n = wdata;
    clr_cnt = 1'b0;
    sh_clr  = 1'b0;
    sh_en   = 1'b0;
    if (!rx_en) begin
      state_n = ST_HUNT;
      clr_cnt = 1'b1;
    end else begin
      case (state)
        ST_HUNT: begin
          clr_cnt = 1'b1;
          sh_clr  = 1'b1;
          bcnt_n  = '0;
          pbit_n  = 1'b0;
          if (tick_en && rx_q && !rxd) state_n = mode_1x ? ST_DATA : ST_START;
        end
        ST_START: if (half_hit) begin
          clr_cnt = 1'b1;
          state_n = rxd ? ST_HUNT : ST_DATA;
        end
        ST_DATA: if (full_hit) begin
          sh_en = 1'b1;
          if (bcnt == last_bit) state_n = par_en ? ST_PAR : ST_STOP;
          else                  bcnt_n  = bcnt + 3'd1;
        end
        ST_PAR: if (full_hit) begin
          pbit_n  = rxd;
          state_n = ST_STOP;
        end
        ST_STOP: if (full_hit) begin
          clr_cnt = 1'b1;
          if (!rxd && (data_al == '0) && !pbit) begin
            state_n = ST_BRKQ;
          end else begin
            wr_n    = 1'b1;
            wdata_n = {1'b0, !rxd, perr, data_al};
            state_n = ST_HUNT;
          end
        end
        ST_BRKQ: if (half_hit) begin
          wr_n = 1'b1;
          if (!rxd) begin
            wdata_n = {1'b1, 1'b1, 1'b0, {DATA_W{1'b0}}};
            state_n = ST_BRKWAIT;
          end else begin
            wdata_n = {1'b0, 1'b1, perr, data_al};
            state_n = ST_HUNT;
          end
        end
        ST_BRKWAIT: if (tick_en && rxd) state_n = ST_HUNT;
        default: state_n = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_HUNT;
      bcnt  <= '0;
      pbit  <= 1'b0;
      rx_q  <= 1'b1;
      wr_q  <= 1'b0;
      wdata <= '0;
    end else begin
      state <= state_n;
      bcnt  <= bcnt_n;
      pbit  <= pbit_n;
      wr_q  <= wr_n;
      wdata <= wdata_n;
      if (tick_en) rx_q <= rxd;
    end
  end

  assign fifo_wr   = wr_q;
  assign fifo_data = wdata;

  // R10: a write only follows an enabled cycle
  p_wr_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> $past(rx_en));

  // R7: the write strobe lasts one clock
  p_wr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |=> !fifo_wr);

  // R2: a start bit that reads high at the check point is dropped at once
  p_rehunt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && state == ST_START && half_hit && rxd) |=> (state == ST_HUNT && !fifo_wr));

  // R8: a break word carries zero data, framing set, parity clear
  p_break_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && fifo_data[BRK_POS]) |->
      (fifo_data[DATA_W-1:0] == '0 && fifo_data[FE_POS] && !fifo_data[PE_POS]));

  // R8: no further entry while a break is held
  p_brk_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BRKWAIT && $past(state == ST_BRKWAIT)) |-> !fifo_wr);

  // R9: direct mode never passes through the mid-start check
  p_1x_nostart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START) |-> !mode_1x);
endmodule

// File: tb/sim_uart_rx_core.sv
module sim_uart_rx_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0;
  logic        tick_en = 1'b0;
  logic        mode_1x = 1'b0;
  logic [1:0]  char_len = 2'd3;
  logic        par_en = 1'b0;
  logic        par_odd = 1'b0;
  logic        rxd = 1'b1;
  logic        fifo_wr;
  logic [10:0] fifo_data;

  int checks = 0;
  int fails = 0;
  int wr_count = 0;
  logic [10:0] expq[$];
  string       tagq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_core u0 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick_en(tick_en),
    .mode_1x(mode_1x), .char_len(char_len), .par_en(par_en),
    .par_odd(par_odd), .rxd(rxd), .fifo_wr(fifo_wr), .fifo_data(fifo_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pop and compare each written entry
  always @(negedge clk) begin
    if (rst_n && fifo_wr) begin
      wr_count++;
      if (expq.size() == 0) begin
        check(1'b0, "R10/R2 unexpected write", int'(fifo_data), 0);
      end else begin
        logic [10:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check(fifo_data == e, t, int'(fifo_data), int'(e));
      end
    end
  end

  task automatic step();
    repeat (3) @(negedge clk);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) step();
  endtask

  // driver: computes the expected word, queues it, then drives the frame
  task automatic frame(input logic [7:0] d, input int code, input bit pen, input bit podd,
                       input bit badpar, input bit stopv, input int low_after,
                       input bit expect_it, input string tag);
    int nb, bl;
    logic [7:0] dm;
    logic pb;
    logic [10:0] e;
    nb = code + 5;
    bl = mode_1x ? 1 : 16;
    dm = d & 8'((1 << nb) - 1);
    pb = pen ? ((^dm) ^ podd ^ badpar) : 1'b0;
    if (!stopv && dm == 8'h00 && !pb && low_after > 0) e = 11'h600;
    else e = {1'b0, !stopv, pen & badpar, dm};
    if (expect_it) begin
      expq.push_back(e);
      tagq.push_back(tag);
    end
    char_len = 2'(code);
    par_en = pen;
    par_odd = podd;
    hold(1'b0, bl);
    for (int i = 0; i < nb; i++) hold(dm[i], bl);
    if (pen) hold(pb, bl);
    hold(stopv, bl);
    if (low_after > 0) hold(1'b0, low_after);
    hold(1'b1, 4);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not finish)");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    check(fifo_wr == 1'b0, "R1 write low in reset", int'(fifo_wr), 0);
    rst_n = 1'b1;
    rx_en = 1'b1;
    hold(1'b1, 20);
    check(wr_count == 0, "R1 idle line writes nothing", wr_count, 0);

    // R3: full bytes, oversampled
    frame(8'hA5, 3, 0, 0, 0, 1, 0, 1, "R3 byte A5");
    frame(8'h3C, 3, 0, 0, 0, 1, 0, 1, "R3 byte 3C");
    frame(8'h01, 3, 0, 0, 0, 1, 0, 1, "R3 byte 01");

    // R4: short characters zero-filled
    frame(8'hFF, 0, 0, 0, 0, 1, 0, 1, "R4 five bits");
    frame(8'hC6, 1, 0, 0, 0, 1, 0, 1, "R4 six bits");
    frame(8'hFE, 2, 0, 0, 0, 1, 0, 1, "R4 seven bits");

    // R5: parity
    frame(8'h5B, 3, 1, 0, 0, 1, 0, 1, "R5 even ok");
    frame(8'h5B, 3, 1, 1, 0, 1, 0, 1, "R5 odd ok");
    frame(8'h12, 3, 1, 0, 1, 1, 0, 1, "R5 even bad");
    frame(8'h2E, 2, 1, 1, 1, 1, 0, 1, "R5 odd bad");

    // R6: framing error with nonzero data
    frame(8'h55, 3, 0, 0, 0, 0, 0, 1, "R6 low stop");

    // R7: exact write point inside the stop bit
    char_len = 2'd3; par_en = 1'b0;
    expq.push_back(11'h042); tagq.push_back("R7 write word");
    hold(1'b0, 16);
    for (int i = 0; i < 8; i++) hold(((8'h42 >> i) & 8'h01) != 0, 16);
    rxd = 1'b1;
    for (int i = 0; i < 9; i++) begin
      step();
      if (i == 7) check(fifo_wr == 1'b0, "R7 no write before stop centre", int'(fifo_wr), 0);
      if (i == 8) check(fifo_wr == 1'b1, "R7 write after stop centre", int'(fifo_wr), 1);
    end
    hold(1'b1, 10);

    // R2: short pulses rejected, hunting restarts at once
    base = wr_count;
    hold(1'b0, 3);
    hold(1'b1, 20);
    hold(1'b0, 8);
    hold(1'b1, 20);
    check(wr_count == base, "R2 short pulses dropped", wr_count - base, 0);
    hold(1'b0, 8);
    hold(1'b1, 1);
    frame(8'h96, 3, 0, 0, 0, 1, 0, 1, "R2 frame right after rejected start");

    // R8: break and near-break
    base = wr_count;
    frame(8'h00, 3, 0, 0, 0, 0, 60, 1, "R8 break word");
    check(wr_count - base == 1, "R8 single break entry", wr_count - base, 1);
    frame(8'h81, 3, 0, 0, 0, 1, 0, 1, "R8 frame after break");
    frame(8'h00, 3, 0, 0, 0, 0, 0, 1, "R8 zero char line high");
    frame(8'h00, 3, 1, 1, 1, 0, 30, 1, "R8 break with odd parity bit zero");

    // R9: direct-clocked mode
    mode_1x = 1'b1;
    hold(1'b1, 3);
    frame(8'h5A, 3, 0, 0, 0, 1, 0, 1, "R9 1x byte");
    frame(8'h33, 2, 1, 1, 0, 1, 0, 1, "R9 1x seven odd");
    frame(8'h0D, 0, 0, 0, 0, 0, 0, 1, "R9 1x framing");
    base = wr_count;
    frame(8'h00, 3, 0, 0, 0, 0, 6, 1, "R9 1x break");
    check(wr_count - base == 1, "R9 1x single break entry", wr_count - base, 1);
    mode_1x = 1'b0;
    hold(1'b1, 4);

    // R10: disabled receiver ignores a full frame
    base = wr_count;
    rx_en = 1'b0;
    frame(8'hC3, 3, 0, 0, 0, 1, 0, 0, "R10 disabled");
    check(wr_count == base, "R10 no write while disabled", wr_count - base, 0);
    // R10: disable in mid-frame drops it
    hold(1'b1, 2);
    rx_en = 1'b1;
    hold(1'b1, 4);
    hold(1'b0, 16);
    hold(1'b1, 40);
    rx_en = 1'b0;
    hold(1'b1, 4);
    rx_en = 1'b1;
    hold(1'b1, 200);
    check(wr_count == base, "R10 aborted frame not written", wr_count - base, 0);
    frame(8'h7E, 3, 0, 0, 0, 1, 0, 1, "R10 frame after enable");

    hold(1'b1, 40);
    check(expq.size() == 0, "R3 all expected entries written", expq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule